// File: doc/BRIEF.md
# Half-Rate Split Significand Multiplier

This block forms the exact unsigned product of two 113-bit significands, as needed by the multiply stage of a quad-precision fused multiply-add. It has no full-width multiplier array. Instead it reuses two narrow unsigned multipliers, each 57 bits on a side. Each operand is cut into a low part and a high part, which gives four partial products. The two narrow units compute these four products in two back-to-back cycles. A small merge stage then shifts the partial products into place and adds them into the full 226-bit result.

Upstream logic offers an operand pair with `inValid`. The pair is taken on any clock edge where `inReady` is also high. Once a pair is taken, `inReady` stays low for one cycle, so the block accepts at most one pair every two clocks. Each accepted pair later produces one single-cycle pulse on `outValid`, with the full product on `outProd`. Products leave in the order their pairs arrived. The narrow multipliers have `MUL_LAT` pipeline stages. The whole block adds exactly two cycles on top of one narrow pass.

Top module: `split_wide_mult`

## Requirements
- R1: `outProd` carries every bit of the exact unsigned product `opA * opB`, 2*OP_W bits wide, with no truncation or rounding.
- R2: Each operand is split into a low part (bits 56..0) and a high part (bits 112..57, zero-extended to 57 bits). The four partial products are placed at bit offsets 0 (low×low), 57 (the sum of both cross terms) and 114 (high×high). Operands with a single bit set on either side of the bit-56/57 boundary give the exact power-of-two product.
- R3: A pair is accepted on a rising edge where `inValid` and `inReady` are both high. `inReady` is low for exactly the one cycle after an acceptance and high at every other time.
- R4: Every accepted pair gives exactly one `outValid` pulse, one cycle long. Results come out in acceptance order, and `outValid` never rises without an accepted pair behind it.
- R5: `outValid` rises exactly MUL_LAT+2 clock edges after the edge that accepted the pair (4 edges with the default MUL_LAT=2).
- R6: When `inValid` is held high, a pair is accepted every second edge, so one product is delivered every two clocks.
- R7: A synchronous active-high `rst` forces `inReady` high and `outValid` low. Any pair in flight when reset is applied produces no output.
- R8: Operands presented with `inValid` high while `inReady` is low are ignored. They produce no output and do not disturb the result of the pair already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair is offered |
| inReady | output | 1 | Block can take a pair on this edge |
| opA | input | OP_W (113) | Multiplicand significand |
| opB | input | OP_W (113) | Multiplier significand |
| outValid | output | 1 | One-cycle pulse: `outProd` holds a finished product |
| outProd | output | 2*OP_W (226) | Full unsigned product |

## Verification
If the phase register goes wrong, the port sequence breaks straight away. `inReady` either stays low for the wrong number of cycles, or the block accepts a second pair while the cross terms of the first are still being formed. The result of that pair is then wrong within MUL_LAT+2 cycles. Errors in the operand split, the zero-extension of the high parts, or the shift offsets show up only in certain bits of the product. A sweep of every single-bit × single-bit operand pair lands one product bit on each position, so any misplaced term is caught at the first `outValid` that uses it. If the delay line or the valid flags slip by one cycle, the pulse arrives off the latency check. It then pairs straight terms from one operand pair with cross terms from its neighbour, which corrupts the middle bits of the product.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;

  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadOps;      // capture a new operand pair
    logic selCross;     // steer cross terms into the narrow units
    logic capStraight;  // straight products are on the narrow outputs
    logic finish;       // cross products are on the narrow outputs
  } ctrlStrobes_t;

endpackage

// File: rtl/narrow_mult.sv
module narrow_mult #(
  parameter int N       = 57,
  parameter int MUL_LAT = 2
) (
  input  logic             clk,
  input  logic [N-1:0]     a,
  input  logic [N-1:0]     b,
  output logic [2*N-1:0]   p
);
  localparam int PW = 2 * N;

  logic [PW-1:0] stage [MUL_LAT];

  always_ff @(posedge clk) begin
    stage[0] <= PW'(a) * PW'(b);
  end

  generate
    for (genvar k = 1; k < MUL_LAT; k++) begin : g_pipe
      always_ff @(posedge clk) begin
        stage[k] <= stage[k-1];
      end
    end
  endgenerate

  assign p = stage[MUL_LAT-1];

endmodule

// File: rtl/split_mul_ctrl.sv
module split_mul_ctrl
  import split_mul_pkg::*;
#(
  parameter int MUL_LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strb
);
  logic               straightPhase;  // narrow units take straight terms this cycle
  logic [MUL_LAT-1:0] issueDly;       // tracks straight terms through the units
  logic               finishQ;
  logic               outValidQ;
  logic               accept;

  assign inReady = !straightPhase;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      straightPhase <= 1'b0;
      issueDly      <= '0;
      finishQ       <= 1'b0;
      outValidQ     <= 1'b0;
    end else begin
      straightPhase <= accept;
      issueDly[0]   <= straightPhase;
      for (int k = 1; k < MUL_LAT; k++) begin
        issueDly[k] <= issueDly[k-1];
      end
      finishQ   <= issueDly[MUL_LAT-1];
      outValidQ <= finishQ;
    end
  end

  assign strb.loadOps     = accept;
  assign strb.selCross    = !straightPhase;
  assign strb.capStraight = issueDly[MUL_LAT-1];
  assign strb.finish      = finishQ;
  assign outValid         = outValidQ;

  // R3: the cycle after an acceptance is never ready
  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  // R4: output pulse lasts one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R7: state right after reset
  assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (inReady && !outValid));

endmodule

// File: rtl/split_mul_dp.sv
module split_mul_dp
  import split_mul_pkg::*;
#(
  parameter int OP_W    = 113,
  parameter int MUL_LAT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  output logic [2*OP_W-1:0]   product
);
  localparam int LO_W  = (OP_W + 1) / 2;
  localparam int HI_W  = OP_W - LO_W;
  localparam int PW    = 2 * LO_W;
  localparam int RES_W = 2 * OP_W;
  localparam int PAD   = 2 * (LO_W - HI_W);

  logic [OP_W-1:0]  opAReg, opBReg;
  logic [LO_W-1:0]  aLo, aHi, bLo, bHi;
  logic [LO_W-1:0]  mulA [2];
  logic [LO_W-1:0]  mulB [2];
  logic [PW-1:0]    mulP [2];
  logic [PW:0]      crossSum;
  logic [RES_W-1:0] straightReg;
  logic [RES_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (strb.loadOps) begin
      opAReg <= opA;
      opBReg <= opB;
    end
  end

  assign aLo = opAReg[LO_W-1:0];
  assign bLo = opBReg[LO_W-1:0];
  assign aHi = LO_W'(opAReg[OP_W-1:LO_W]);
  assign bHi = LO_W'(opBReg[OP_W-1:LO_W]);

  // unit 0 always takes the low part of A, unit 1 the high part
  assign mulA[0] = aLo;
  assign mulA[1] = aHi;
  assign mulB[0] = strb.selCross ? bHi : bLo;
  assign mulB[1] = strb.selCross ? bLo : bHi;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_unit
      narrow_mult #(.N(LO_W), .MUL_LAT(MUL_LAT)) u_mult (
        .clk (clk),
        .a   (mulA[g]),
        .b   (mulB[g]),
        .p   (mulP[g])
      );
    end
  endgenerate

  assign crossSum = {1'b0, mulP[0]} + {1'b0, mulP[1]};

  always_ff @(posedge clk) begin
    if (strb.capStraight) begin
      straightReg <= (RES_W'(mulP[1]) << PW) | RES_W'(mulP[0]);
    end
    if (strb.finish) begin
      resultReg <= straightReg + (RES_W'(crossSum) << LO_W);
    end
  end

  assign product = resultReg;

  generate
    if (PAD > 0) begin : g_padchk
      // R2: high x high uses zero-extended halves, so its top bits are clear
      assert_hh_width_R2: assert property (@(posedge clk) disable iff (rst)
        strb.capStraight |-> (mulP[1][PW-1 -: PAD] == '0));
    end
  endgenerate

endmodule

// File: rtl/split_wide_mult.sv
module split_wide_mult
  import split_mul_pkg::*;
#(
  parameter int OP_W    = 113,
  parameter int MUL_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              outValid,
  output logic [2*OP_W-1:0] outProd
);
  localparam int INFLIGHT_MAX = (MUL_LAT + 2) / 2 + 1;

  ctrlStrobes_t strb;

  split_mul_ctrl #(.MUL_LAT(MUL_LAT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  split_mul_dp #(.OP_W(OP_W), .MUL_LAT(MUL_LAT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .product (outProd)
  );

  // pairs accepted but not yet delivered
  logic [7:0] inFlight;
  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else inFlight <= inFlight + 8'(inValid && inReady) - 8'(outValid);
  end

  // R4: a result pulse always has an accepted pair behind it
  assert_no_orphan_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != 0));

  // R6: half-rate issue keeps the number in flight bounded
  assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (rst)
    inFlight <= 8'(INFLIGHT_MAX));

endmodule

// File: tb/sim_split_wide_mult.sv
`timescale 1ns/1ps
module sim_split_wide_mult;
  localparam int OP_W    = 113;
  localparam int MUL_LAT = 2;
  localparam int RES_W   = 2 * OP_W;
  localparam int LAT     = MUL_LAT + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [OP_W-1:0]   opA = '0;
  logic [OP_W-1:0]   opB = '0;
  logic              outValid;
  logic [RES_W-1:0]  outProd;

  always #2.5 clk = ~clk;

  split_wide_mult #(.OP_W(OP_W), .MUL_LAT(MUL_LAT)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .outValid(outValid), .outProd(outProd)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int edgeCnt = 0;
  int lastAcceptEdge = -10;
  bit expReadyLow = 0;
  bit prevStalled = 0;
  bit lastAccepted = 0;
  logic [RES_W-1:0] expQ[$];
  int               edgeQ[$];

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] refMul(input logic [OP_W-1:0] a,
                                               input logic [OP_W-1:0] b);
    return RES_W'(a) * RES_W'(b);
  endfunction

  // one cycle: observe outputs, then drive the next inputs
  task automatic step(input bit v, input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    logic [RES_W-1:0] e;
    int acc;
    @(negedge clk);
    check(inReady == !expReadyLow, "R3", "inReady level", RES_W'(inReady), RES_W'(!expReadyLow));
    if (outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "unexpected outValid", RES_W'(1), RES_W'(0));
      end else begin
        e = expQ.pop_front();
        acc = edgeQ.pop_front();
        check(outProd == e, "R1", "product", outProd, e);
        check(edgeCnt - acc == LAT, "R5", "latency", RES_W'(edgeCnt - acc), RES_W'(LAT));
      end
    end
    expReadyLow = 0;
    inValid = v; opA = a; opB = b;
    lastAccepted = v && inReady;
    if (lastAccepted) begin
      if (prevStalled)
        check(edgeCnt + 1 - lastAcceptEdge == 2, "R6", "accept spacing",
              RES_W'(edgeCnt + 1 - lastAcceptEdge), RES_W'(2));
      expQ.push_back(refMul(a, b));
      edgeQ.push_back(edgeCnt + 1);
      lastAcceptEdge = edgeCnt + 1;
      expReadyLow = 1;
    end
    prevStalled = v && !inReady;
  endtask

  task automatic send(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    do step(1'b1, a, b); while (!lastAccepted);
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 3; i++) step(1'b0, '0, '0);
    check(expQ.size() == 0, "R4", "results outstanding", RES_W'(expQ.size()), '0);
  endtask

  function automatic logic [OP_W-1:0] rnd();
    return OP_W'({$urandom, $urandom, $urandom, $urandom});
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check(inReady == 1'b1, "R7", "inReady after reset", RES_W'(inReady), RES_W'(1));
    check(outValid == 1'b0, "R7", "outValid after reset", RES_W'(outValid), RES_W'(0));

    // corner operands
    send('0, '0);
    send('1, '0);
    send('1, '1);
    send('1, OP_W'(1));
    send(OP_W'(1) << 56, OP_W'(1) << 57);     // R2 boundary bits
    send(OP_W'(1) << 57, OP_W'(1) << 57);     // R2
    send(OP_W'((OP_W'(1) << 57) - 1), '1);    // R2 full low part
    send('1 ^ OP_W'((OP_W'(1) << 57) - 1), '1); // R2 full high part
    drain();

    // R2, R1, R6: every single-bit x single-bit pair, back to back
    for (int i = 0; i < OP_W; i++)
      for (int j = 0; j < OP_W; j++)
        send(OP_W'(1) << i, OP_W'(1) << j);
    drain();

    // R8: junk offered while not ready must be ignored
    for (int n = 0; n < 200; n++) begin
      send(rnd(), rnd());
      step(1'b1, rnd(), rnd());   // inReady is low here
      step(1'b0, rnd(), rnd());
    end
    drain();

    // random traffic with gaps
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 3) != 0) send(rnd(), rnd());
      else step(1'b0, rnd(), rnd());
    end
    drain();

    // R7: reset with a pair in flight
    send(rnd(), rnd());
    step(1'b0, '0, '0);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    expQ.delete(); edgeQ.delete();
    expReadyLow = 0; prevStalled = 0;
    check(inReady == 1'b1, "R7", "inReady after mid-flight reset", RES_W'(inReady), RES_W'(1));
    for (int i = 0; i < LAT + 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R7", "no output after reset", RES_W'(outValid), RES_W'(0));
    end
    send(rnd(), '1);
    drain();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule